// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a register-mapped general-purpose I/O controller for 28 pins. Software reaches it over a plain 32-bit register bus with single-cycle reads and writes. The bus is always ready: a write takes effect at the clock edge where `bus_sel` and `bus_wr` are high. Read data is combinational from the current register state, so it has no valid/ready handshake and no back-pressure.

Each pin has an output latch and a direction bit. Writing ones to a set word or a clear word drives latch bits high or low. The output enable follows the direction bit. A per-pin select chooses between plain GPIO and an alternate function.

Pin inputs first pass through a two-flop synchronizer. Each pin can then flag a rising edge, a falling edge, or both, into a sticky status word. Writing a one to a status bit clears it. Status bits 0 to 10 each drive their own interrupt line. Bits 11 to 27 are ORed onto one shared interrupt line.

Top module: `gpio_edge_ctrl`

Register map (word offsets; `bus_addr[1:0]` must be zero, otherwise the access is ignored and reads return zero):

| Offset | Register |
|---|---|
| 0x00 | synchronized pin level |
| 0x04 | direction |
| 0x08 | output set |
| 0x0C | output clear |
| 0x10 | rising enable |
| 0x14 | falling enable |
| 0x18 | edge status |
| 0x1C | alternate-function select |

## Requirements
- R1: After reset, every register reads zero, `pin_oe`, `pin_out` and `alt_sel` are zero, and no interrupt line is high.
- R2: Offset 0x00 returns the pin inputs after two synchronizer flops. A change on `pin_in` set up before clock edge k is readable after edge k+1. Writes to offset 0x00 have no effect.
- R3: The direction register at 0x04 reads back what was written. Each bit drives `pin_oe`, where 1 means output and 0 means input.
- R4: Writing to 0x08 sets the `pin_out` bits that are written as 1. Writing to 0x0C clears the bits that are written as 1. Bits written as 0 keep their value. Both offsets read as zero.
- R5: When a rising-enable bit (0x10) is 1, a 0-to-1 change of that pin's synchronized level sets its status bit one edge after the synchronized level changes.
- R6: When a falling-enable bit (0x14) is 1, a 1-to-0 change sets the status bit. With both enables set, either change sets it. With both clear, the status bit is never set.
- R7: Writing 1 to a status bit at 0x18 clears it. A 0 leaves it unchanged. If a new enabled edge and a clear hit the same bit in the same cycle, the bit stays set.
- R8: `irq_pin[i]` for i in 0..10 is high exactly while status bit i is set.
- R9: `irq_shared` is high exactly while any of status bits 11 to 27 is set.
- R10: The alternate-function register at 0x1C reads back what was written and drives `alt_sel`, where 1 selects the alternate function.
- R11: Read bits 31:28 are always zero. Unaligned addresses read zero and their writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_sel | input | 1 | register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | byte address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational |
| pin_in | input | 28 | raw pin inputs |
| pin_out | output | 28 | output latch |
| pin_oe | output | 28 | output enable (direction) |
| alt_sel | output | 28 | alternate-function select |
| irq_pin | output | 11 | dedicated interrupts for pins 0..10 |
| irq_shared | output | 1 | OR of status bits 11..27 |

## Verification
The assertions assume that the bus issues at most one write per cycle. They also assume that `pin_in` only changes between clock edges. That lets a status bit's appearance be traced to an enabled edge seen one cycle earlier, and lets the output latch be held stable whenever neither output word is written. The stimulus drives every input on the falling clock edge and issues one bus operation per cycle. It mixes random pin toggles and random register writes, including random status clears, so that clears often land on the same cycle as new edges.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
  typedef enum logic [2:0] {
    RIDX_LEVEL = 3'd0,
    RIDX_DIR   = 3'd1,
    RIDX_SET   = 3'd2,
    RIDX_CLR   = 3'd3,
    RIDX_RISE  = 3'd4,
    RIDX_FALL  = 3'd5,
    RIDX_STAT  = 3'd6,
    RIDX_ALT   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 28,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] edge_hit,
  output logic [WIDTH-1:0] status
);
  logic [WIDTH-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else level_q <= level;
  end

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      logic went_up, went_down;
      assign went_up   = level[i] & ~level_q[i];
      assign went_down = ~level[i] & level_q[i];
      assign edge_hit[i] = (went_up & rise_en[i]) | (went_down & fall_en[i]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status[i] <= 1'b0;
        else if (edge_hit[i]) status[i] <= 1'b1;
        else if (clr_mask[i]) status[i] <= 1'b0;
      end
    end
  endgenerate

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == '0) |=> ((status & $past(status)) == $past(status))); // R7

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(rise_en | fall_en)) == '0)); // R6

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((status & $past(edge_hit)) == $past(edge_hit))); // R7
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ctl_pkg::*;
#(
  parameter int WIDTH  = 28,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [WIDTH-1:0]  level,
  input  logic [WIDTH-1:0]  status,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  rise_q,
  output logic [WIDTH-1:0]  fall_q,
  output logic [WIDTH-1:0]  alt_q,
  output logic [WIDTH-1:0]  clr_mask
);
  localparam int PAD = DATA_W - WIDTH;

  logic       aligned;
  logic       wr_go;
  reg_idx_e   idx;
  logic [WIDTH-1:0] wd;
  logic [WIDTH-1:0] rd;
  logic       unused_wdata_hi;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign idx     = reg_idx_e'(bus_addr[4:2]);
  assign wr_go   = bus_sel & bus_wr & aligned;
  assign wd      = bus_wdata[WIDTH-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:WIDTH];

  assign clr_mask = (wr_go && idx == RIDX_STAT) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      alt_q  <= '0;
    end else if (wr_go) begin
      case (idx)
        RIDX_DIR:  dir_q  <= wd;
        RIDX_SET:  out_q  <= out_q | wd;
        RIDX_CLR:  out_q  <= out_q & ~wd;
        RIDX_RISE: rise_q <= wd;
        RIDX_FALL: fall_q <= wd;
        RIDX_ALT:  alt_q  <= wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd = '0;
    if (aligned) begin
      case (idx)
        RIDX_LEVEL: rd = level;
        RIDX_DIR:   rd = dir_q;
        RIDX_RISE:  rd = rise_q;
        RIDX_FALL:  rd = fall_q;
        RIDX_STAT:  rd = status;
        RIDX_ALT:   rd = alt_q;
        default:    rd = '0;
      endcase
    end
  end

  assign bus_rdata = {{PAD{1'b0}}, rd};

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && (idx == RIDX_SET || idx == RIDX_CLR)) |=> $stable(out_q)); // R4

  AST_SET_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && idx == RIDX_SET) |=> ((out_q & $past(out_q)) == $past(out_q))); // R4

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && idx == RIDX_DIR) |=> $stable(dir_q)); // R3

  always_comb begin
    if (rst_n) AST_UPPER_ZERO: assert (bus_rdata[DATA_W-1:WIDTH] == '0); // R11
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int WIDTH = 28,
  parameter int NDED  = 11
) (
  input  logic [WIDTH-1:0] status,
  output logic [NDED-1:0]  irq_pin,
  output logic             irq_shared
);
  genvar i;
  generate
    for (i = 0; i < NDED; i++) begin : g_ded
      assign irq_pin[i] = status[i];
    end
  endgenerate

  assign irq_shared = |status[WIDTH-1:NDED];
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int PIN_COUNT   = 28,
  parameter int DED_IRQS    = 11,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe,
  output logic [PIN_COUNT-1:0] alt_sel,
  output logic [DED_IRQS-1:0]  irq_pin,
  output logic                 irq_shared
);
  logic [PIN_COUNT-1:0] level, status, edge_hit, clr_mask, rise_q, fall_q;

  gpio_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .q_out(level));

  gpio_edge #(.WIDTH(PIN_COUNT)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(level), .rise_en(rise_q),
    .fall_en(fall_q), .clr_mask(clr_mask), .edge_hit(edge_hit),
    .status(status));

  gpio_regs #(.WIDTH(PIN_COUNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .level(level), .status(status), .dir_q(pin_oe), .out_q(pin_out),
    .rise_q(rise_q), .fall_q(fall_q), .alt_q(alt_sel), .clr_mask(clr_mask));

  gpio_irq #(.WIDTH(PIN_COUNT), .NDED(DED_IRQS)) u_irq (
    .status(status), .irq_pin(irq_pin), .irq_shared(irq_shared));

  AST_DED_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_pin & ~$past(irq_pin) & ~$past(edge_hit[DED_IRQS-1:0])) == '0)); // R8

  AST_SHARED_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_shared) |-> $past(|edge_hit[PIN_COUNT-1:DED_IRQS])); // R9
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [27:0] pin_in = '0, pin_out, pin_oe, alt_sel;
  logic [10:0] irq_pin;
  logic irq_shared;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_edge_ctrl u_dut (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata, .pin_in, .pin_out, .pin_oe, .alt_sel, .irq_pin, .irq_shared);

  logic [27:0] m_s1, m_s2, m_prev, m_stat, m_dir, m_out, m_ren, m_fen, m_alt;

  task automatic model_reset();
    {m_s1, m_s2, m_prev, m_stat, m_dir, m_out, m_ren, m_fen, m_alt} = '0;
  endtask

  task automatic model_step();
    logic [27:0] hit, clr, wd;
    bit go;
    wd  = bus_wdata[27:0];
    go  = bus_sel && bus_wr && bus_addr[1:0] == 2'b00;
    hit = (m_s2 & ~m_prev & m_ren) | (~m_s2 & m_prev & m_fen);
    clr = (go && bus_addr == 5'h18) ? wd : '0;
    m_stat = (m_stat & ~clr) | hit;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    if (go) case (bus_addr)
      5'h04: m_dir = wd;
      5'h08: m_out = m_out | wd;
      5'h0C: m_out = m_out & ~wd;
      5'h10: m_ren = wd;
      5'h14: m_fen = wd;
      5'h1C: m_alt = wd;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_read(logic [4:0] a);
    case (a)
      5'h00: return {4'h0, m_s2};
      5'h04: return {4'h0, m_dir};
      5'h10: return {4'h0, m_ren};
      5'h14: return {4'h0, m_fen};
      5'h18: return {4'h0, m_stat};
      5'h1C: return {4'h0, m_alt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
  endtask

  task automatic chk_outs();
    chk("R3 pin_oe", {4'h0, pin_oe}, {4'h0, m_dir});
    chk("R4 pin_out", {4'h0, pin_out}, {4'h0, m_out});
    chk("R10 alt_sel", {4'h0, alt_sel}, {4'h0, m_alt});
    chk("R8 irq_pin", {21'h0, irq_pin}, {21'h0, m_stat[10:0]});
    chk("R9 irq_shared", {31'h0, irq_shared}, {31'h0, |m_stat[27:11]});
  endtask

  task automatic rd(logic [4:0] a, string req);
    bus_sel = 1; bus_wr = 0; bus_addr = a; #1;
    chk(req, bus_rdata, exp_read(a));
    bus_sel = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_sel = 0; bus_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 32; a += 4) begin
      bus_sel = 1; bus_wr = 0; bus_addr = 5'(a); #1;
      chk("R1 reset reg", bus_rdata, 32'h0);
    end
    bus_sel = 0;
    chk_outs();
    // R3/R10/R4 register writes
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, "R3 dir readback"); rd(5'h04, "R11 upper zero");
    wr(5'h1C, 32'h0A5A_5A5A); rd(5'h1C, "R10 alt readback");
    wr(5'h08, 32'h0000_00F0); wr(5'h08, 32'h0000_0003);
    chk("R4 set keeps", {4'h0, pin_out}, 32'h0000_00F3);
    wr(5'h0C, 32'h0000_0030);
    chk("R4 clear", {4'h0, pin_out}, 32'h0000_00C3);
    rd(5'h08, "R4 set reads zero"); rd(5'h0C, "R4 clear reads zero");
    wr(5'h06, 32'h0000_FFFF); chk("R11 unaligned write ignored", {4'h0, pin_oe}, 32'h0FFF_FFFF);
    bus_sel = 1; bus_wr = 0; bus_addr = 5'h05; #1;
    chk("R11 unaligned read zero", bus_rdata, 32'h0); bus_sel = 0;
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, "R2 level write ignored");
    // R2 latency: change set before edge k, visible after edge k+1
    pin_in = 28'h000_0001; cyc(); rd(5'h00, "R2 not yet");
    chk("R2 one edge", bus_rdata, 32'h0);
    cyc(); rd(5'h00, "R2 level"); chk("R2 two edges", bus_rdata, 32'h1);
    // R5 rising on pin 3 and pin 20
    wr(5'h10, 32'h0010_0008);
    pin_in = 28'h010_0009; cyc(); cyc();
    chk("R5 not yet", {21'h0, irq_pin}, 32'h0);
    cyc();
    chk("R5 rise pin3", {21'h0, irq_pin}, 32'h8);
    chk("R9 shared from pin20", {31'h0, irq_shared}, 32'h1);
    // R7 zero write no effect; w1c
    wr(5'h18, 32'h0); rd(5'h18, "R7 zero write");
    wr(5'h18, 32'h0010_0000); chk("R9 shared cleared", {31'h0, irq_shared}, 32'h0);
    // R6 both enables on pin 3, fall coincides with clear -> stays set
    wr(5'h14, 32'h0000_0008);
    pin_in = 28'h010_0001; cyc(); cyc();
    wr(5'h18, 32'h0000_0008);
    chk("R7 edge wins", {21'h0, irq_pin}, 32'h8);
    wr(5'h18, 32'h0000_0008); chk("R7 w1c", {21'h0, irq_pin}, 32'h0);
    // R6 no enable: pin 5 toggles, no status
    pin_in = 28'h010_0021; repeat (4) cyc(); pin_in = 28'h010_0001; repeat (4) cyc();
    chk("R6 masked", {21'h0, irq_pin}, 32'h0);
    chk_outs();
    // random phase
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) pin_in = pin_in ^ (28'($urandom) & 28'($urandom));
      bus_sel = 0; bus_wr = 0;
      if (r >= 5) begin
        bus_sel = 1; bus_wr = ($urandom_range(0, 1) == 1);
        bus_addr = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'($urandom_range(0, 7) * 4);
        bus_wdata = $urandom;
      end
      cyc();
      bus_sel = 0; bus_wr = 0;
      if (k % 10 == 0) begin chk_outs(); rd(5'($urandom_range(0, 7) * 4), "R2 R5 R6 R7 random read"); end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule